// File: doc/BRIEF.md
# SPI Chip-Select Encoder/Decoder

This block drives the four active-low chip-select lines of an SPI master. When a transfer starts, it takes a 4-bit select code from one of two sources. In fixed mode the code is a value held in a mode setting. In variable mode it is the code that travels with each transmit word, so each word can address a different device.

A decode-mode input chooses how the code reaches the pins:

- **Priority mode.** The lowest clear bit of the code picks one of four directly wired devices.
- **Binary mode.** The code is placed unchanged on the pins, where an external 4-to-16 decoder turns it into one of up to 15 device selects.

The code with all bits set is reserved for "no device". A start request that carries it is refused and reported on an error pulse. While a transfer is open, the block also reports which per-device configuration slot applies. The shifter raises `start` to open a transfer and `done` to close it.

The code, the decode mode and the slot are captured at the start. They stay fixed until the transfer ends, or until the block is disabled.

Top module: `spi_cs_select`

## Requirements
- R1: After reset, `cs_n` is 1111, `busy` is 0 and `code_err` is 0.
- R2: With `var_sel` = 0, a transfer uses `fixed_code` as the select code, and `word_code` has no effect.
- R3: With `var_sel` = 1, a transfer uses `word_code` as the select code, and `fixed_code` has no effect.
- R4: With `dec_mode` = 0, an accepted start drives `cs_n` low only on bit i, where i is the lowest clear bit of the code; the other three bits stay high. For example, code 0101 gives `cs_n` = 1101.
- R5: With `dec_mode` = 1, an accepted start drives `cs_n` equal to the 4-bit code.
- R6: A start whose selected code is 1111 opens no transfer in either decode mode. `cs_n` stays 1111, `busy` stays 0, and `code_err` is 1 for exactly the one cycle after the request.
- R7: While `busy` is high, `slot` gives the configuration slot:
  - with `dec_mode` = 1, it is code bits [3:2], so devices 0–3 map to slot 0, devices 4–7 to slot 1, and so on;
  - with `dec_mode` = 0, it is the index of the asserted output.
- R8: When `done` is high while busy, the next cycle has `busy` = 0 and `cs_n` = 1111.
- R9: A `start` while `busy` is high is ignored, and `cs_n` and `slot` keep their values.
- R10: While `enable` is 0, `start` opens no transfer and raises no error. Dropping `enable` during a transfer closes it on the next cycle, with `cs_n` = 1111.
- R11: Changes to `var_sel`, `dec_mode`, `fixed_code` or `word_code` during a transfer do not change `cs_n` or `slot`.
- R12: Outputs are registered: the effect of `start`, `done` or `enable` appears one clock after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces all selects high |
| var_sel | input | 1 | 0 = code from `fixed_code`, 1 = code from `word_code` |
| dec_mode | input | 1 | 0 = lowest-zero priority drive, 1 = binary code on pins |
| fixed_code | input | 4 | Select code used in fixed mode |
| word_code | input | 4 | Select code carried with the current transmit word |
| start | input | 1 | Request to open a transfer |
| done | input | 1 | Current transfer finished; release the selects |
| cs_n | output | 4 | Active-low chip-select pins |
| slot | output | 2 | Configuration slot of the selected device |
| busy | output | 1 | A transfer is open |
| code_err | output | 1 | One-cycle pulse when a reserved code was refused |

## Verification
All 16 code values are swept under every combination of source select and decode mode. The unused source always holds a different code, so a mix-up between the two sources shows up on the pins.

The sweep separates priority resolution from binary pass-through. It also separates the reserved code from every valid code, and checks the slot grouping at each group boundary.

During each open transfer, all settings are flipped and a second start is issued, to show that both are ignored. Separate sequences cover a start while disabled and dropping the enable mid-transfer.

// File: rtl/spi_cs_select.sv
module spi_cs_select #(
  parameter int CS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              var_sel,
  input  logic              dec_mode,
  input  logic [CS_W-1:0]   fixed_code,
  input  logic [CS_W-1:0]   word_code,
  input  logic              start,
  input  logic              done,
  output logic [CS_W-1:0]   cs_n,
  output logic [$clog2(CS_W)-1:0] slot,
  output logic              busy,
  output logic              code_err
);

  localparam int SLOT_W = $clog2(CS_W);
  localparam logic [CS_W-1:0] NO_DEV = '1;

  logic [CS_W-1:0]   code_sel;
  logic [SLOT_W-1:0] pri_idx;
  logic [CS_W-1:0]   cs_next;
  logic [SLOT_W-1:0] slot_next;
  logic              req, reserved, accept, reject;
  logic              dmode_q;

  assign code_sel = var_sel ? word_code : fixed_code;
  assign reserved = &code_sel;
  assign req      = enable && start && !busy;
  assign accept   = req && !reserved;
  assign reject   = req && reserved;

  always_comb begin
    pri_idx = '0;
    for (int i = CS_W - 1; i >= 0; i--)
      if (!code_sel[i]) pri_idx = SLOT_W'(i);
  end

  assign cs_next   = dec_mode ? code_sel : ~(CS_W'(1) << pri_idx);
  assign slot_next = dec_mode ? code_sel[CS_W-1 -: SLOT_W] : pri_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cs_n     <= NO_DEV;
      slot     <= '0;
      code_err <= 1'b0;
      dmode_q  <= 1'b0;
    end else begin
      code_err <= reject;
      if (!enable || (busy && done)) begin
        busy <= 1'b0;
        cs_n <= NO_DEV;
      end else if (accept) begin
        busy    <= 1'b1;
        cs_n    <= cs_next;
        slot    <= slot_next;
        dmode_q <= dec_mode;
      end
    end
  end

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n == NO_DEV);

  a_r4_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !dmode_q |-> $countones(~cs_n) == 1);

  a_r6_no_reserved_drive: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cs_n != NO_DEV);

  a_r6_err_no_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> !busy);

  a_r10_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy && cs_n == NO_DEV && !code_err);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cs_n) && $stable(slot));

endmodule

// File: tb/test_spi_cs_select.sv
`timescale 1ns/1ps
module test_spi_cs_select;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, var_sel = 1'b0, dec_mode = 1'b0;
  logic [3:0] fixed_code = 4'h0, word_code = 4'h0;
  logic       start = 1'b0, done = 1'b0;
  logic [3:0] cs_n;
  logic [1:0] slot;
  logic       busy, code_err;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  spi_cs_select i_spi_cs_select (
    .clk(clk), .rst_n(rst_n), .enable(enable), .var_sel(var_sel),
    .dec_mode(dec_mode), .fixed_code(fixed_code), .word_code(word_code),
    .start(start), .done(done), .cs_n(cs_n), .slot(slot), .busy(busy),
    .code_err(code_err));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cs(input logic [3:0] c, input logic dm);
    if (dm) return c;
    for (int i = 0; i < 4; i++) if (!c[i]) return ~(4'b1 << i);
    return 4'hF;
  endfunction

  function automatic logic [1:0] exp_slot(input logic [3:0] c, input logic dm);
    if (dm) return c / 4;
    for (int i = 0; i < 4; i++) if (!c[i]) return 2'(i);
    return 2'd0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 cs_n", cs_n, 4'hF);
    chk("R1 busy", busy, 0);
    chk("R1 err", code_err, 0);
    rst_n = 1'b1;
    enable = 1'b1;
    @(negedge clk);

    for (int vs = 0; vs < 2; vs++)
      for (int dm = 0; dm < 2; dm++)
        for (int c = 0; c < 16; c++) begin
          logic [3:0] code = 4'(c);
          string src = vs ? "R3" : "R2";
          var_sel = vs[0]; dec_mode = dm[0];
          if (vs != 0) begin word_code = code; fixed_code = code ^ 4'h6; end
          else         begin fixed_code = code; word_code = code ^ 4'h6; end
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
          if (code == 4'hF) begin
            chk("R6 cs_n", cs_n, 4'hF);
            chk("R6 busy", busy, 0);
            chk("R6 err", code_err, 1);
            @(negedge clk);
            chk("R6 err pulse", code_err, 0);
          end else begin
            chk(dm ? "R5 cs_n" : "R4 cs_n", cs_n, exp_cs(code, dm[0]));
            chk({src, " source"}, cs_n, exp_cs(code, dm[0]));
            chk("R7 slot", slot, exp_slot(code, dm[0]));
            chk("R12 busy", busy, 1);
            chk("R6 err quiet", code_err, 0);
            var_sel = ~var_sel; dec_mode = ~dec_mode;
            fixed_code = 4'h0; word_code = 4'h0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R9 R11 cs_n hold", cs_n, exp_cs(code, dm[0]));
            chk("R9 R11 slot hold", slot, exp_slot(code, dm[0]));
            done = 1'b1;
            @(negedge clk);
            done = 1'b0;
            chk("R8 cs_n", cs_n, 4'hF);
            chk("R8 busy", busy, 0);
          end
        end

    var_sel = 1'b0; dec_mode = 1'b0; fixed_code = 4'h0;
    enable = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 no start", busy, 0);
    chk("R10 cs_n", cs_n, 4'hF);
    fixed_code = 4'hF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 no err", code_err, 0);
    enable = 1'b1; fixed_code = 4'h4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 open", cs_n, 4'hE);
    enable = 1'b0;
    @(negedge clk);
    chk("R10 drop busy", busy, 0);
    chk("R10 drop cs_n", cs_n, 4'hF);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule